// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire PHY management bus. A host asks for one transaction at a time: a read or a write of a 16-bit register, picked by a 5-bit PHY address and a 5-bit register address. The block produces the management clock and the whole frame on the data line: a run of ones, the start pattern, the opcode, both addresses, the turnaround, and the 16 data bits. For a write it drives the turnaround and the data. For a read it releases the line and shifts in the data the PHY returns.

On a read, the block samples the first turnaround bit. A pulled-up line there means no PHY is answering. The block then clocks the bus idle for a fixed number of further cycles, ends the transaction and raises an error flag instead of returning data. The management clock half-period is a run-time divider of the system clock. The data line appears as separate enable, value and input signals, so pad cells and pull-ups stay outside the block. All pin outputs come from registers. The management clock rests high, and between transactions the data line is released.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset: `mdc_o` is 1, `mdio_oe_o` is 0, `done_o` is 0, `err_o` is 0 and `rd_data_o` is 0.
- R2: Each frame begins with PRE_CYC (default 32) MDC cycles with the line driven to 1.
- R3: The next 14 MDC cycles drive, in order: start 0,1; opcode 1,0 for a read (`rd_i`=1) or 0,1 for a write; PHY address bits 4..0; register address bits 4..0.
- R4: Every low and every high MDC phase inside a transaction lasts `half_div_i`+1 system clocks. The value is taken when the start is accepted.
- R5: The line value and the line enable change only while MDC is low. They hold steady through each high phase.
- R6: A read whose first turnaround sample is 0 releases the line from the first turnaround cycle onward. It captures 16 bits, MSB first, each sampled at the end of a high phase of the cycles that follow the two turnaround cycles. It adds one trailing MDC cycle (65 cycles in total with the default preamble) and loads the word into `rd_data_o` with `err_o` at 0.
- R7: A read whose first turnaround sample is 1 keeps the line released and runs FLUSH_CYC (default 32) more MDC cycles, 79 in total with the defaults. It then sets `err_o` to 1 and leaves `rd_data_o` unchanged.
- R8: A write drives the turnaround as 1,0 and then `wdata_i` bits 15..0. After that comes one MDC cycle with the line released, 65 cycles in total with the defaults.
- R9: `done_o` is a single-cycle pulse at the end of the last MDC high phase. MDC is high during the pulse, and there is exactly one pulse per transaction.
- R10: While a transaction is running, `start_i` is ignored, and so are any changes on the other request inputs.
- R11: `rd_data_o` changes only when a successful read completes, so writes and failed reads leave it as it was. `err_o` clears when a start is accepted and otherwise holds until the next start.
- R12: Between transactions, MDC stays high, no extra MDC cycles occur, and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start_i | input | 1 | request a transaction (accepted when idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | register address |
| wdata_i | input | 16 | write data |
| half_div_i | input | DIV_W | MDC half-period minus one, in system clocks |
| mdio_i | input | 1 | sampled level of the data line |
| mdc_o | output | 1 | management clock |
| mdio_oe_o | output | 1 | data line drive enable |
| mdio_out_o | output | 1 | data line drive value |
| rd_data_o | output | 16 | last successfully read word |
| done_o | output | 1 | transaction finished pulse |
| err_o | output | 1 | last read found no PHY |

## Verification
The bench builds the block with its default parameters: DIV_W of 8 and a 32-cycle preamble and flush. Every frame therefore has its standard length, and the error path runs its full 79 cycles. Reads, writes and missing-PHY reads are swept at divider values 0, 1 and 3, which covers one-clock phases as well as longer ones. A sweep over all 32 PHY addresses, with mirrored register addresses and varied data, reaches every address bit value in both directions. A start pulse with altered request fields is also injected in the middle of a frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int HDR_BITS  = 14;
  localparam int TA_BITS   = 2;
  localparam int DATA_BITS = 16;
  localparam int TX_BITS   = HDR_BITS + TA_BITS + DATA_BITS;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;
  localparam logic [1:0] TA_RD   = 2'b11;

  function automatic logic [TX_BITS-1:0] build_tx(
    input logic rd, input logic [4:0] phy, input logic [4:0] rg,
    input logic [DATA_BITS-1:0] wd);
    return {SOF_PAT, (rd ? OP_RD : OP_WR), phy, rg, (rd ? TA_RD : TA_WR), wd};
  endfunction
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] lim;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lim <= '0;
      cnt <= '0;
    end else begin
      if (load_i) lim <= half_i;
      if (!run_i || load_i)  cnt <= '0;
      else if (cnt == lim)   cnt <= '0;
      else                   cnt <= cnt + 1'b1;
    end
  end

  assign tick_o = run_i && !load_i && (cnt == lim);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int PRE_CYC   = 32,
  parameter int FLUSH_CYC = 32,
  parameter int SLOT_W    = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic rd_i,
  input  logic tick_i,
  input  logic sample_i,
  output logic busy_o,
  output logic mdc_o,
  output logic drive_o,
  output logic pre_o,
  output logic shift_o,
  output logic cap_o,
  output logic rd_o,
  output logic done_o,
  output logic fail_o
);
  localparam logic [SLOT_W-1:0] S_HDR  = SLOT_W'(PRE_CYC);
  localparam logic [SLOT_W-1:0] S_TA1  = SLOT_W'(PRE_CYC + 14);
  localparam logic [SLOT_W-1:0] S_D0   = SLOT_W'(PRE_CYC + 16);
  localparam logic [SLOT_W-1:0] S_DL   = SLOT_W'(PRE_CYC + 31);
  localparam logic [SLOT_W-1:0] S_TAIL = SLOT_W'(PRE_CYC + 32);
  localparam logic [SLOT_W-1:0] S_FL   = SLOT_W'(FLUSH_CYC - 1);

  logic              hi;
  logic              flush;
  logic [SLOT_W-1:0] slot;
  logic              last;
  logic              end_hi;
  logic              ta_bad;

  assign end_hi = busy_o && hi && tick_i;
  assign last   = flush ? (slot == S_FL) : (slot == S_TAIL);
  assign ta_bad = rd_o && !flush && (slot == S_TA1) && sample_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      hi     <= 1'b0;
      flush  <= 1'b0;
      slot   <= '0;
      mdc_o  <= 1'b1;
      rd_o   <= 1'b0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        hi     <= 1'b0;
        flush  <= 1'b0;
        slot   <= '0;
        mdc_o  <= 1'b0;
        rd_o   <= rd_i;
      end else if (busy_o && tick_i) begin
        if (!hi) begin
          hi    <= 1'b1;
          mdc_o <= 1'b1;
        end else if (ta_bad) begin
          flush <= 1'b1;
          slot  <= '0;
          hi    <= 1'b0;
          mdc_o <= 1'b0;
        end else if (last) begin
          busy_o <= 1'b0;
          hi     <= 1'b0;
          done_o <= 1'b1;
          fail_o <= flush;
        end else begin
          slot  <= slot + 1'b1;
          hi    <= 1'b0;
          mdc_o <= 1'b0;
        end
      end
    end
  end

  assign shift_o = end_hi && !flush && !last && !ta_bad && (slot >= S_HDR);
  assign cap_o   = end_hi && !flush && rd_o && (slot >= S_D0) && (slot <= S_DL);
  assign drive_o = busy_o && !flush && ((slot < S_TA1) || (!rd_o && (slot < S_TAIL)));
  assign pre_o   = (slot < S_HDR);
endmodule

// File: rtl/mdio_shift_path.sv
module mdio_shift_path
  import mdio_mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic                 rd_i,
  input  logic [4:0]           phy_i,
  input  logic [4:0]           reg_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  input  logic                 shift_i,
  input  logic                 cap_i,
  input  logic                 bit_i,
  output logic                 tx_bit_o,
  output logic [DATA_BITS-1:0] rx_word_o
);
  logic [TX_BITS-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr     <= '0;
      rx_word_o <= '0;
    end else begin
      if (load_i)       tx_sr <= build_tx(rd_i, phy_i, reg_i, wdata_i);
      else if (shift_i) tx_sr <= {tx_sr[TX_BITS-2:0], 1'b0};
      if (cap_i) rx_word_o <= {rx_word_o[DATA_BITS-2:0], bit_i};
    end
  end

  assign tx_bit_o = tx_sr[TX_BITS-1];
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int PRE_CYC   = 32,
  parameter int FLUSH_CYC = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 rd_i,
  input  logic [4:0]           phy_addr_i,
  input  logic [4:0]           reg_addr_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  input  logic [DIV_W-1:0]     half_div_i,
  input  logic                 mdio_i,
  output logic                 mdc_o,
  output logic                 mdio_oe_o,
  output logic                 mdio_out_o,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int SPAN   = (PRE_CYC + 33 > FLUSH_CYC) ? PRE_CYC + 33 : FLUSH_CYC;
  localparam int SLOT_W = $clog2(SPAN + 1);

  logic                 seq_busy;
  logic                 accept;
  logic                 tick;
  logic                 seq_mdc;
  logic                 seq_drive;
  logic                 seq_pre;
  logic                 seq_shift;
  logic                 seq_cap;
  logic                 seq_rd;
  logic                 seq_done;
  logic                 seq_fail;
  logic                 tx_bit;
  logic [DATA_BITS-1:0] rx_word;

  assign accept = start_i && !seq_busy;

  mdio_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .half_i (half_div_i),
    .run_i  (seq_busy),
    .tick_o (tick)
  );

  mdio_frame_seq #(
    .PRE_CYC   (PRE_CYC),
    .FLUSH_CYC (FLUSH_CYC),
    .SLOT_W    (SLOT_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .rd_i     (rd_i),
    .tick_i   (tick),
    .sample_i (mdio_i),
    .busy_o   (seq_busy),
    .mdc_o    (seq_mdc),
    .drive_o  (seq_drive),
    .pre_o    (seq_pre),
    .shift_o  (seq_shift),
    .cap_o    (seq_cap),
    .rd_o     (seq_rd),
    .done_o   (seq_done),
    .fail_o   (seq_fail)
  );

  mdio_shift_path shift_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .rd_i      (rd_i),
    .phy_i     (phy_addr_i),
    .reg_i     (reg_addr_i),
    .wdata_i   (wdata_i),
    .shift_i   (seq_shift),
    .cap_i     (seq_cap),
    .bit_i     (mdio_i),
    .tx_bit_o  (tx_bit),
    .rx_word_o (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_o      <= 1'b1;
      mdio_oe_o  <= 1'b0;
      mdio_out_o <= 1'b1;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      mdc_o      <= seq_mdc;
      mdio_oe_o  <= seq_drive;
      mdio_out_o <= seq_pre ? 1'b1 : tx_bit;
      done_o     <= seq_done;
      if (accept)        err_o <= 1'b0;
      else if (seq_done) err_o <= seq_fail;
      if (seq_done && seq_rd && !seq_fail) rd_data_o <= rx_word;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        mdc_o,
  input logic        mdio_oe_o,
  input logic        mdio_out_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rd_data_o
);
  assert_drive_steady_high_R5: assert property (@(posedge clk) disable iff (rst)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_out_o) && $stable(mdio_oe_o)));

  assert_done_mdc_high_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> mdc_o);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_err_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(rd_data_o));

  assert_idle_lines_R12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (mdc_o && !mdio_oe_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (seq_busy),
  .mdc_o      (mdc_o),
  .mdio_oe_o  (mdio_oe_o),
  .mdio_out_o (mdio_out_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .rd_data_o  (rd_data_o)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             start = 1'b0;
  logic             rd = 1'b0;
  logic [4:0]       phy = '0;
  logic [4:0]       rg = '0;
  logic [15:0]      wd = '0;
  logic [DIV_W-1:0] hdiv = '0;
  logic             mdio_i;
  logic             mdc_o, mdio_oe_o, mdio_out_o, done_o, err_o;
  logic [15:0]      rd_data_o;

  logic        phy_en = 1'b0, phy_val = 1'b1, phy_present = 1'b1, rd_mode = 1'b0;
  logic [15:0] phy_word = '0;

  assign mdio_i = mdio_oe_o ? mdio_out_o : (phy_en ? phy_val : 1'b1);

  mdio_mgmt_master #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .rd_i(rd), .phy_addr_i(phy),
    .reg_addr_i(rg), .wdata_i(wd), .half_div_i(hdiv), .mdio_i(mdio_i),
    .mdc_o(mdc_o), .mdio_oe_o(mdio_oe_o), .mdio_out_o(mdio_out_o),
    .rd_data_o(rd_data_o), .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_bad = 0;
  int rises = 0, since = 0, phase_bad = 0, done_cnt = 0, done_low = 0, steady_bad = 0;
  int cur_h = 1;
  bit seen = 1'b0;
  logic prev_mdc = 1'b1, rise_oe = 1'b0, rise_out = 1'b0;
  bit oe_log [0:127];
  bit out_log[0:127];
  logic [15:0] exp_rd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pin monitor and PHY model
  always @(negedge clk) begin
    since = since + 1;
    if (mdc_o !== prev_mdc) begin
      if (seen && since != cur_h) phase_bad++;
      since = 0;
      seen  = 1'b1;
      if (mdc_o) begin
        if (rises < 128) begin
          oe_log[rises]  = mdio_oe_o;
          out_log[rises] = mdio_out_o;
        end
        rise_oe  = mdio_oe_o;
        rise_out = mdio_out_o;
        rises++;
      end else begin
        phy_en = 1'b0;
        phy_val = 1'b1;
        if (rd_mode && phy_present) begin
          if (rises == 46 || rises == 47) begin phy_en = 1'b1; phy_val = 1'b0; end
          else if (rises >= 48 && rises <= 63) begin
            phy_en = 1'b1; phy_val = phy_word[63 - rises];
          end
        end
      end
    end else if (mdc_o && (mdio_oe_o !== rise_oe || mdio_out_o !== rise_out) && rises > 0) begin
      steady_bad++;
    end
    if (done_o) begin
      done_cnt++;
      if (!mdc_o) done_low++;
    end
    prev_mdc = mdc_o;
  end

  task automatic run_txn(input bit r, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] w, input logic [DIV_W-1:0] hd,
                         input bit present, input logic [15:0] word, input bit poke);
    int t, bad, exp_rises;
    logic [13:0] hv;
    logic [17:0] bv;
    string tag;
    @(posedge clk); #1;
    rises = 0; since = 0; phase_bad = 0; done_cnt = 0; done_low = 0; steady_bad = 0;
    seen = 1'b0; cur_h = int'(hd) + 1;
    rd_mode = r; phy_present = present; phy_word = word; phy_en = 1'b0;
    rd = r; phy = pa; rg = ra; wd = w; hdiv = hd; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    @(posedge clk); #1;
    chk(err_o == 1'b0, "R11", "err cleared after start", err_o, 0);
    if (poke) begin
      repeat (40) @(posedge clk);
      #1; start = 1'b1; rd = ~r; phy = ~pa; rg = ~ra; wd = ~w; hdiv = hd + 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 20000) begin @(posedge clk); #1; t++; end
    if (done_cnt == 0) chk(1'b0, "R9", "done timeout", 0, 1);
    repeat (4 * (int'(hd) + 1) + 4) @(posedge clk);
    #1;
    exp_rises = r ? (present ? 65 : 79) : 65;
    tag = r ? (present ? "R6" : "R7") : "R8";
    chk(rises == exp_rises, tag, "MDC cycle count", rises, exp_rises);
    bad = 0;
    for (int i = 0; i < 32; i++) if (!(oe_log[i] && out_log[i])) bad++;
    chk(bad == 0, "R2", "preamble bits", bad, 0);
    hv = {2'b01, (r ? 2'b10 : 2'b01), pa, ra};
    bad = 0;
    for (int i = 0; i < 14; i++) if (!oe_log[32+i] || out_log[32+i] != hv[13-i]) bad++;
    chk(bad == 0, "R3", "start/opcode/address bits", bad, 0);
    bad = 0;
    if (r) begin
      for (int i = 46; i < exp_rises && i < 128; i++) if (oe_log[i]) bad++;
    end else begin
      bv = {2'b10, w};
      for (int i = 0; i < 18; i++) if (!oe_log[46+i] || out_log[46+i] != bv[17-i]) bad++;
      if (oe_log[64]) bad++;
    end
    chk(bad == 0, tag, "turnaround/data/release bits", bad, 0);
    chk(phase_bad == 0, "R4", "phase length errors", phase_bad, 0);
    chk(steady_bad == 0, "R5", "line change during high", steady_bad, 0);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(done_low == 0, "R9", "done with MDC low", done_low, 0);
    chk(mdc_o == 1'b1 && mdio_oe_o == 1'b0, "R12", "idle lines", {mdc_o, mdio_oe_o}, 2);
    if (r && present) exp_rd = word;
    chk(rd_data_o == exp_rd, r ? (present ? "R6" : "R11") : "R11", "read data",
        rd_data_o, exp_rd);
    chk(err_o == (r && !present), r ? "R7" : "R8", "error flag", err_o, (r && !present));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1; rst = 1'b0;
    @(posedge clk); #1;
    chk(mdc_o == 1'b1, "R1", "reset mdc", mdc_o, 1);
    chk(mdio_oe_o == 1'b0, "R1", "reset oe", mdio_oe_o, 0);
    chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
    chk(err_o == 1'b0, "R1", "reset err", err_o, 0);
    chk(rd_data_o == 16'h0, "R1", "reset rd_data", rd_data_o, 0);

    foreach (hdiv_set[k]) begin
      run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, hdiv_set[k], 1'b1, 16'hA5C3 ^ {8'h0, hdiv_set[k]}, 1'b0);
      run_txn(1'b0, 5'h0A, 5'h15, 16'h8001 ^ {hdiv_set[k], 8'h0}, hdiv_set[k], 1'b1, 16'h0, 1'b0);
      run_txn(1'b1, 5'h1F, 5'h00, 16'h0000, hdiv_set[k], 1'b0, 16'hFFFF, 1'b0);
    end

    // R10: mid-frame start with altered request must not disturb the frame
    run_txn(1'b1, 5'h03, 5'h1C, 16'h1234, 8'd1, 1'b1, 16'h5A0F, 1'b1);
    chk(rd_data_o == 16'h5A0F && err_o == 1'b0, "R10", "read result after ignored start",
        rd_data_o, 16'h5A0F);
    run_txn(1'b0, 5'h11, 5'h06, 16'hC3A5, 8'd0, 1'b1, 16'h0, 1'b1);
    chk(rd_data_o == 16'h5A0F, "R10", "write leaves read data after ignored start",
        rd_data_o, 16'h5A0F);

    for (int p = 0; p < 32; p++) begin
      run_txn(p[0], 5'(p), 5'(31 - p), 16'(p * 16'h0801), 8'd0, 1'b1,
              ~16'(p * 16'h1111), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  logic [DIV_W-1:0] hdiv_set [3] = '{8'd0, 8'd1, 8'd3};
endmodule